// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the basic control word of a 10/100 Ethernet transceiver and applies its diagnostic settings to the media-independent nibble interface. A management agent writes and reads the word through a parallel register port made of an address, write data, a write strobe and a combinational read word. The block controls these functions:

- a soft reset;
- loopback;
- a forced speed and a forced duplex, which take effect only while auto-negotiation is off;
- auto-negotiation enable and a restart request;
- power-down and isolate;
- collision test.

The restart request goes to an external negotiation engine as a single-cycle pulse. Its status bit stays set until the engine acknowledges it.

On the MII side the block sits between the MAC nibble streams and the line. In loopback it returns the transmit nibble on the receive nibble. In collision test it drives the collision pin from the transmit enable. When isolated it releases its MAC-facing outputs to high impedance. The MII nibble streams carry no back-pressure: every nibble is taken in the cycle it is presented, so there is no ready signal on either side. The register port also has no handshake: a write takes effect at the clock edge where the strobe is high, and the read word follows the address in the same cycle.

Top module: `phy_ctrl_reg`

## Requirements
- R1: After rst_n is released, a read of register address 0 returns 0x3100. That value has these bits set: bit 13 (speed, 1 = 100 Mb/s), bit 12 (auto-negotiation enable) and bit 8 (duplex, 1 = full). All other bits are 0.
- R2: A write of address 0 with bit 15 set does two things at that edge. It restores every field to its R1 value, and it starts a hold window of RST_HOLD cycles (16 by default). During the window, bit 15 reads 1, soft_reset is 1 and writes to address 0 are ignored. In the read that follows the window, bit 15 reads 0.
- R3: While bit 14 (loopback) is 1, rxd equals txd and rx_dv equals tx_en. At the same time line_tx_en and line_txd are 0, and line_rxd and line_rx_dv have no effect on rxd or rx_dv.
- R4: While bit 12 reads 1, a write leaves bits 13 and 8 unchanged. The auto-negotiation setting in force before the write decides this, not the value being written.
- R5: While bit 12 reads 0, a write to address 0 loads bits 13 and 8, and force_speed_100 and force_full_duplex follow them.
- R6: Bit 11 (power-down) and bit 10 (isolate) are written and read back like ordinary bits and reset to 0. power_down mirrors bit 11. Reads and writes keep working in either state.
- R7: While bit 10 is 1, mii_oe is 0 and rxd, rx_dv and col are at high impedance. Otherwise mii_oe is 1.
- R8: A write with bit 9 set makes an_restart 1 for the cycle after the write edge. Bit 9 then reads 1 until the edge at which an_restart_ack is high. If that ack edge is also a new restart write, the bit stays 1.
- R9: When bit 7 (collision test) is 1 and pcs_bypass is 0, col equals tx_en in both duplex modes. Otherwise col equals line_col, or 0 when loopback is on.
- R10: Bits 6 to 0 always read 0, and writing them changes nothing.
- R11: A write to any address other than 0 changes nothing, and a read of such an address returns 0.
- R12: A single write with both bit 15 and bit 9 set behaves as a soft reset only. an_restart stays 0 and bit 9 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_addr | input | 5 | Register address |
| mgmt_wdata | input | 16 | Write data |
| mgmt_we | input | 1 | Write strobe, one write per high cycle |
| mgmt_rdata | output | 16 | Read word for mgmt_addr, 0 for other addresses |
| an_restart | output | 1 | Single-cycle restart request to the negotiation engine |
| an_restart_ack | input | 1 | Engine acknowledge, clears the restart status bit |
| pcs_bypass | input | 1 | Coding-bypass flag from another register, disables collision test |
| soft_reset | output | 1 | High during the soft-reset hold window |
| an_enable | output | 1 | Auto-negotiation enable field |
| force_speed_100 | output | 1 | Manual speed setting, 1 = 100 Mb/s |
| force_full_duplex | output | 1 | Manual duplex setting, 1 = full |
| power_down | output | 1 | Power-down field |
| tx_en | input | 1 | MAC transmit enable |
| txd | input | 4 | MAC transmit nibble |
| line_tx_en | output | 1 | Transmit enable toward the line |
| line_txd | output | 4 | Transmit nibble toward the line |
| line_rx_dv | input | 1 | Receive valid from the line |
| line_rxd | input | 4 | Receive nibble from the line |
| line_col | input | 1 | Collision from the line |
| rx_dv | output | 1 | Receive valid to the MAC, tri-stated when isolated |
| rxd | output | 4 | Receive nibble to the MAC, tri-stated when isolated |
| col | output | 1 | Collision to the MAC, tri-stated when isolated |
| mii_oe | output | 1 | High while the MAC-facing outputs are driven |

## Verification
The restart request can meet two other events at the same clock edge. One is its own acknowledge: the bench presents an_restart_ack in the same cycle as a fresh restart write and expects bit 9 to stay set, with a new pulse. The other is a soft reset: one write carries both bit 15 and bit 9, and the bench expects no pulse and a cleared status bit. A behavioural model in the bench steps through the same edges. It is compared against every output and the read word on every cycle, so a wrong winner in either collision shows up in the cycle where it happens.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

  localparam int CW_BITS = 16;

  // Bit positions of the control word; other blocks decode these positions.
  localparam int B_SRST    = 15;
  localparam int B_LOOP    = 14;
  localparam int B_SPEED   = 13;
  localparam int B_ANEN    = 12;
  localparam int B_PDN     = 11;
  localparam int B_ISO     = 10;
  localparam int B_RESTART = 9;
  localparam int B_DUPLEX  = 8;
  localparam int B_COLT    = 7;
  localparam int RSVD_W    = 7;

  typedef struct packed {
    logic loopback;
    logic speed_100;
    logic an_en;
    logic pwr_down;
    logic isolate;
    logic full_dup;
    logic coll_test;
  } pcr_fields_t;

  localparam pcr_fields_t PCR_DEFAULT = '{
    loopback:  1'b0,
    speed_100: 1'b1,
    an_en:     1'b1,
    pwr_down:  1'b0,
    isolate:   1'b0,
    full_dup:  1'b1,
    coll_test: 1'b0
  };

endpackage

// File: rtl/pcr_seq.sv
// Self-clearing controls: soft-reset hold counter and restart handshake.
module pcr_seq #(
  parameter int RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic srst_bit,
  input  logic restart_bit,
  input  logic restart_ack,
  output logic busy,
  output logic soft_start,
  output logic field_we,
  output logic restart_pulse,
  output logic restart_pend
);

  localparam int CNT_W = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             restart_req;

  assign busy        = (hold_cnt != '0);
  assign soft_start  = wr_hit && !busy && srst_bit;
  assign field_we    = wr_hit && !busy && !srst_bit;
  assign restart_req = field_we && restart_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt      <= '0;
      restart_pulse <= 1'b0;
      restart_pend  <= 1'b0;
    end else begin
      if (soft_start) hold_cnt <= CNT_W'(RST_HOLD);
      else if (busy)  hold_cnt <= hold_cnt - 1'b1;

      restart_pulse <= restart_req;

      if (soft_start)       restart_pend <= 1'b0;
      else if (restart_req) restart_pend <= 1'b1;
      else if (restart_ack) restart_pend <= 1'b0;
    end
  end

  AST_PULSE_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> restart_pend); // R8

  AST_SRST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |=> (!restart_pulse && !restart_pend && busy)); // R12

  AST_HOLD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!field_we && !soft_start)); // R2

endmodule

// File: rtl/pcr_fields.sv
// Control fields with the auto-negotiation write lock on speed and duplex.
module pcr_fields
  import phy_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_start,
  input  logic        field_we,
  input  pcr_fields_t wr_word,
  output pcr_fields_t fq
);

  pcr_fields_t fnext;

  always_comb begin
    fnext = fq;
    if (soft_start) begin
      fnext = PCR_DEFAULT;
    end else if (field_we) begin
      fnext.loopback  = wr_word.loopback;
      fnext.an_en     = wr_word.an_en;
      fnext.pwr_down  = wr_word.pwr_down;
      fnext.isolate   = wr_word.isolate;
      fnext.coll_test = wr_word.coll_test;
      if (!fq.an_en) begin
        fnext.speed_100 = wr_word.speed_100;
        fnext.full_dup  = wr_word.full_dup;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fq <= PCR_DEFAULT;
    else        fq <= fnext;
  end

  AST_SPEED_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (fq.an_en && !soft_start) |=> ($stable(fq.speed_100) && $stable(fq.full_dup))); // R4

  AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_start |=> (fq == PCR_DEFAULT)); // R2

endmodule

// File: rtl/pcr_mii_path.sv
// Diagnostic routing on the nibble interface.
module pcr_mii_path #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loopback,
  input  logic             coll_test,
  input  logic             isolate,
  input  logic             pcs_bypass,
  input  logic             tx_en,
  input  logic [NIB_W-1:0] txd,
  input  logic             line_rx_dv,
  input  logic [NIB_W-1:0] line_rxd,
  input  logic             line_col,
  output logic             line_tx_en,
  output logic [NIB_W-1:0] line_txd,
  output logic             rx_dv,
  output logic [NIB_W-1:0] rxd,
  output logic             col,
  output logic             mii_oe
);

  logic             rx_dv_int;
  logic [NIB_W-1:0] rxd_int;
  logic             col_int;
  logic             colt_on;

  assign colt_on    = coll_test && !pcs_bypass;
  assign line_tx_en = loopback ? 1'b0 : tx_en;
  assign line_txd   = loopback ? '0 : txd;
  assign rx_dv_int  = loopback ? tx_en : line_rx_dv;
  assign col_int    = colt_on ? tx_en : (loopback ? 1'b0 : line_col);
  assign mii_oe     = !isolate;

  for (genvar i = 0; i < NIB_W; i++) begin : g_rx_lane
    assign rxd_int[i] = loopback ? txd[i] : line_rxd[i];
    assign rxd[i]     = mii_oe ? rxd_int[i] : 1'bz;
  end

  assign rx_dv = mii_oe ? rx_dv_int : 1'bz;
  assign col   = mii_oe ? col_int : 1'bz;

  AST_LOOP_NO_LINE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    loopback |-> (!line_tx_en && rxd_int == txd)); // R3

  AST_COLT_FOLLOWS_TXEN: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_test && !pcs_bypass) |-> (col_int == tx_en)); // R9

endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 0,
  parameter int RST_HOLD = 16,
  parameter int NIB_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [15:0]       mgmt_wdata,
  input  logic              mgmt_we,
  output logic [15:0]       mgmt_rdata,
  output logic              an_restart,
  input  logic              an_restart_ack,
  input  logic              pcs_bypass,
  output logic              soft_reset,
  output logic              an_enable,
  output logic              force_speed_100,
  output logic              force_full_duplex,
  output logic              power_down,
  input  logic              tx_en,
  input  logic [NIB_W-1:0]  txd,
  output logic              line_tx_en,
  output logic [NIB_W-1:0]  line_txd,
  input  logic              line_rx_dv,
  input  logic [NIB_W-1:0]  line_rxd,
  input  logic              line_col,
  output logic              rx_dv,
  output logic [NIB_W-1:0]  rxd,
  output logic              col,
  output logic              mii_oe
);

  logic        addr_hit;
  logic        wr_hit;
  logic        busy;
  logic        soft_start;
  logic        field_we;
  logic        restart_pend;
  pcr_fields_t fq;
  pcr_fields_t wr_word;
  logic [CW_BITS-1:0] word_q;
  logic        rsvd_unused;

  assign addr_hit = (mgmt_addr == ADDR_W'(REG_ADDR));
  assign wr_hit   = mgmt_we && addr_hit;

  assign wr_word = '{
    loopback:  mgmt_wdata[B_LOOP],
    speed_100: mgmt_wdata[B_SPEED],
    an_en:     mgmt_wdata[B_ANEN],
    pwr_down:  mgmt_wdata[B_PDN],
    isolate:   mgmt_wdata[B_ISO],
    full_dup:  mgmt_wdata[B_DUPLEX],
    coll_test: mgmt_wdata[B_COLT]
  };
  assign rsvd_unused = ^mgmt_wdata[RSVD_W-1:0];

  pcr_seq #(.RST_HOLD(RST_HOLD)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_hit        (wr_hit),
    .srst_bit      (mgmt_wdata[B_SRST]),
    .restart_bit   (mgmt_wdata[B_RESTART]),
    .restart_ack   (an_restart_ack),
    .busy          (busy),
    .soft_start    (soft_start),
    .field_we      (field_we),
    .restart_pulse (an_restart),
    .restart_pend  (restart_pend)
  );

  pcr_fields u_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_start (soft_start),
    .field_we   (field_we),
    .wr_word    (wr_word),
    .fq         (fq)
  );

  pcr_mii_path #(.NIB_W(NIB_W)) u_mii (
    .clk        (clk),
    .rst_n      (rst_n),
    .loopback   (fq.loopback),
    .coll_test  (fq.coll_test),
    .isolate    (fq.isolate),
    .pcs_bypass (pcs_bypass),
    .tx_en      (tx_en),
    .txd        (txd),
    .line_rx_dv (line_rx_dv),
    .line_rxd   (line_rxd),
    .line_col   (line_col),
    .line_tx_en (line_tx_en),
    .line_txd   (line_txd),
    .rx_dv      (rx_dv),
    .rxd        (rxd),
    .col        (col),
    .mii_oe     (mii_oe)
  );

  always_comb begin
    word_q            = '0;
    word_q[B_SRST]    = busy;
    word_q[B_LOOP]    = fq.loopback;
    word_q[B_SPEED]   = fq.speed_100;
    word_q[B_ANEN]    = fq.an_en;
    word_q[B_PDN]     = fq.pwr_down;
    word_q[B_ISO]     = fq.isolate;
    word_q[B_RESTART] = restart_pend;
    word_q[B_DUPLEX]  = fq.full_dup;
    word_q[B_COLT]    = fq.coll_test;
  end

  assign mgmt_rdata        = addr_hit ? word_q : '0;
  assign soft_reset        = busy;
  assign an_enable         = fq.an_en;
  assign force_speed_100   = fq.speed_100;
  assign force_full_duplex = fq.full_dup;
  assign power_down        = fq.pwr_down;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_rdata[RSVD_W-1:0] == '0); // R10

  AST_FOREIGN_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_we && !addr_hit) |=> ($stable(fq) && !an_restart)); // R11

  AST_ISO_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_rdata[B_ISO] && addr_hit) |-> !mii_oe); // R7

endmodule

// File: tb/tb_phy_ctrl_reg.sv
module tb_phy_ctrl_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mgmt_addr = '0;
  logic [15:0] mgmt_wdata = '0;
  logic        mgmt_we = 1'b0;
  logic [15:0] mgmt_rdata;
  logic        an_restart;
  logic        an_restart_ack = 1'b0;
  logic        pcs_bypass = 1'b0;
  logic        soft_reset, an_enable, force_speed_100, force_full_duplex, power_down;
  logic        tx_en = 1'b0;
  logic [3:0]  txd = '0;
  logic        line_tx_en;
  logic [3:0]  line_txd;
  logic        line_rx_dv = 1'b0;
  logic [3:0]  line_rxd = '0;
  logic        line_col = 1'b0;
  wire         rx_dv;
  wire  [3:0]  rxd;
  wire         col;
  logic        mii_oe;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  phy_ctrl_reg dut (
    .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
    .mgmt_we(mgmt_we), .mgmt_rdata(mgmt_rdata), .an_restart(an_restart),
    .an_restart_ack(an_restart_ack), .pcs_bypass(pcs_bypass), .soft_reset(soft_reset),
    .an_enable(an_enable), .force_speed_100(force_speed_100),
    .force_full_duplex(force_full_duplex), .power_down(power_down), .tx_en(tx_en),
    .txd(txd), .line_tx_en(line_tx_en), .line_txd(line_txd), .line_rx_dv(line_rx_dv),
    .line_rxd(line_rxd), .line_col(line_col), .rx_dv(rx_dv), .rxd(rxd), .col(col),
    .mii_oe(mii_oe)
  );

  // Behavioural reference state
  int m_lb, m_spd, m_an, m_pd, m_iso, m_dup, m_colt, m_cnt, m_pend, m_pulse;

  task automatic model_defaults();
    m_lb = 0; m_spd = 1; m_an = 1; m_pd = 0; m_iso = 0; m_dup = 1; m_colt = 0;
  endtask

  initial begin
    model_defaults(); m_cnt = 0; m_pend = 0; m_pulse = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      model_defaults(); m_cnt = 0; m_pend = 0; m_pulse = 0;
    end else begin
      int w;
      bit hit;
      w   = mgmt_wdata;
      hit = mgmt_we && mgmt_addr == 0 && m_cnt == 0;
      if (hit && w[15]) begin
        model_defaults(); m_cnt = 16; m_pend = 0; m_pulse = 0;
      end else if (hit) begin
        int old_an;
        old_an = m_an;
        m_lb = w[14]; m_an = w[12]; m_pd = w[11]; m_iso = w[10]; m_colt = w[7];
        if (old_an == 0) begin m_spd = w[13]; m_dup = w[8]; end
        m_pulse = w[9];
        if (w[9]) m_pend = 1;
        else if (an_restart_ack) m_pend = 0;
      end else begin
        if (m_cnt > 0) m_cnt--;
        m_pulse = 0;
        if (an_restart_ack) m_pend = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_word();
    int v;
    v = 0;
    v[15] = (m_cnt != 0); v[14] = m_lb[0]; v[13] = m_spd[0]; v[12] = m_an[0];
    v[11] = m_pd[0]; v[10] = m_iso[0]; v[9] = m_pend[0]; v[8] = m_dup[0]; v[7] = m_colt[0];
    return v;
  endfunction

  // Compare every cycle, away from both clock edges
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int ew, ecol;
      ew = (mgmt_addr == 0) ? model_word() : 0;
      if (mgmt_addr != 0) chk("R11 rdata foreign", mgmt_rdata, 0);
      else begin
        chk("R2 bit15", mgmt_rdata[15], ew[15]);
        chk("R8 bit9", mgmt_rdata[9], ew[9]);
        chk("R4 bits13_8", {mgmt_rdata[13], mgmt_rdata[8]}, {ew[13], ew[8]});
        chk("R10 reserved", mgmt_rdata[6:0], 0);
        chk("R6 word", mgmt_rdata, ew);
      end
      chk("R2 soft_reset", soft_reset, m_cnt != 0);
      chk("R8 an_restart", an_restart, m_pulse);
      chk("R5 speed", force_speed_100, m_spd);
      chk("R5 duplex", force_full_duplex, m_dup);
      chk("R6 power_down", power_down, m_pd);
      chk("R6 an_enable", an_enable, m_an);
      chk("R7 mii_oe", mii_oe, !m_iso);
      chk("R3 line_tx_en", line_tx_en, m_lb ? 0 : tx_en);
      chk("R3 line_txd", line_txd, m_lb ? 0 : txd);
      if (!m_iso) begin
        chk("R3 rxd", rxd, m_lb ? txd : line_rxd);
        chk("R3 rx_dv", rx_dv, m_lb ? tx_en : line_rx_dv);
        ecol = (m_colt && !pcs_bypass) ? tx_en : (m_lb ? 0 : line_col);
        chk("R9 col", col, ecol);
      end
    end
  end

  // Background nibble traffic; the streams carry no back-pressure
  always @(negedge clk) begin
    tx_en      <= 1'($urandom);
    txd        <= 4'($urandom);
    line_rx_dv <= 1'($urandom);
    line_rxd   <= 4'($urandom);
    line_col   <= 1'($urandom);
  end

  task automatic wr(int addr, int data, bit ack = 0);
    @(negedge clk);
    mgmt_addr = 5'(addr); mgmt_wdata = 16'(data); mgmt_we = 1'b1; an_restart_ack = ack;
    @(negedge clk);
    mgmt_addr = '0; mgmt_we = 1'b0; an_restart_ack = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 reset word", mgmt_rdata, 16'h3100);

    wr(0, 16'h1000);             // R4: speed/duplex cleared but locked
    idle(2);
    wr(0, 16'h0000);             // an off; speed still locked by old an
    wr(0, 16'h0000);             // R5: speed/duplex now written to 0
    idle(2);
    wr(0, 16'h2100);             // R5: back to 100/full
    wr(0, 16'h4000);             // R3: loopback
    idle(12);
    wr(0, 16'h0080);             // R9: collision test
    idle(6);
    pcs_bypass = 1'b1; idle(6); pcs_bypass = 1'b0;
    wr(0, 16'h4080);             // R9 with loopback
    idle(6);
    wr(0, 16'h0400);             // R7: isolate
    idle(6);
    wr(0, 16'h0800);             // R6: power-down
    idle(2);
    wr(0, 16'h0C7F);             // R10: reserved bits written
    idle(2);
    wr(3, 16'hFFFF);             // R11: foreign address
    idle(2);
    wr(0, 16'h1200);             // R8: restart
    idle(3);
    @(negedge clk); an_restart_ack = 1'b1; @(negedge clk); an_restart_ack = 1'b0;
    idle(2);
    wr(0, 16'h1200);
    idle(2);
    wr(0, 16'h1200, 1'b1);       // R8: restart write and ack at once
    idle(2);
    @(negedge clk); an_restart_ack = 1'b1; @(negedge clk); an_restart_ack = 1'b0;
    wr(0, 16'h0000);
    wr(0, 16'h8000);             // R2: soft reset
    wr(0, 16'h4000);             // ignored during hold
    idle(20);
    wr(0, 16'h4C80);
    wr(0, 16'h8200);             // R12: reset and restart together
    #2;
    chk("R12 no pulse", an_restart, 0);
    chk("R12 bit9 clear", mgmt_rdata[9], 0);
    idle(20);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    done = 1;
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule